// File: doc/BRIEF.md
# Prioritized Interrupt Vector Dispatcher

This block sits between the event sources of a processor and its control logic. Six request lanes feed it. A lane either reports an exception from the instruction just retired, or raises an external interrupt (two lanes: a non-maskable one and a maskable one), or signals a fault found while fetching, decoding or executing an instruction. Each request is a one-cycle raise pulse with an 8-bit type number. The block latches the request as pending and keeps it until the core services it.

Among the eligible pending lanes, the block picks the one with the highest fixed priority. It then reads the 32-bit handler address for that lane's type number from a 256-entry vector table. The table read is registered. The selected type and its handler address appear one cycle later, together with a dispatch strobe, and stay there until the core acknowledges. The table is filled through a plain write port. A maskable interrupt only takes part while the interrupt-enable input is high.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, disp_valid is 0 and nothing is pending.
- R2: Lanes of src_raise are indexed 0 = prior-instruction exception, 1 = non-maskable external, 2 = maskable external, 3 = fetch fault, 4 = decode fault, 5 = execute fault. Lane i takes its type number from src_type[8*i+7:8*i]. Among eligible pending lanes the lowest index is dispatched first.
- R3: A pending maskable lane (index 2) is not eligible while int_en is 0. It stays pending and is dispatched once int_en is 1.
- R4: A pending non-maskable lane (index 1) is dispatched whatever the value of int_en.
- R5: A raise pulse sets a lane pending at the next edge. If no dispatch is outstanding, disp_valid rises at the edge after that. disp_type then equals the lane's captured type number, and disp_addr equals the table entry at that type number.
- R6: While disp_valid is 1 and disp_ack is 0, disp_valid, disp_type and disp_addr hold their values.
- R7: disp_ack with disp_valid at 1 clears disp_valid and the pending bit of the serviced lane only. Other lanes stay pending and are dispatched afterwards.
- R8: A table write to the entry being read in the same cycle leaves the dispatched address at the old contents. Later reads return the new value.
- R9: A raise on a lane that is already pending, and is not being acknowledged in that cycle, is ignored. The first type number is kept and no second dispatch follows.
- R10: disp_ack while disp_valid is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| int_en | input | 1 | Enable for the maskable external lane |
| src_raise | input | 6 | One-cycle raise pulse per lane |
| src_type | input | 48 | Type number per lane, 8 bits per lane |
| tbl_wr_en | input | 1 | Vector table write enable |
| tbl_wr_idx | input | 8 | Vector table entry to write |
| tbl_wr_data | input | 32 | Handler address to store |
| disp_ack | input | 1 | Core accepts the current dispatch |
| disp_valid | output | 1 | Dispatch strobe, held until acknowledged |
| disp_type | output | 8 | Type number of the dispatched event |
| disp_addr | output | 32 | Handler address from the vector table |

## Verification
The bench builds the block with its defaults: 8-bit type numbers, which gives the full 256-entry table, and 32-bit handler addresses. Every entry is loaded with a distinct computed value, so a wrong index shows up in the address. Type numbers at both ends of the range (0x00 and 0xFF) are dispatched. A same-cycle write and read of one entry can be arranged exactly, because the read occurs in the one cycle after the pending bit is set.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  localparam int NSRC      = 6;
  localparam int SRC_EXC   = 0;
  localparam int SRC_NMI   = 1;
  localparam int SRC_INTR  = 2;
  localparam int SRC_FETCH = 3;
  localparam int SRC_DEC   = 4;
  localparam int SRC_EXE   = 5;

  localparam logic [NSRC-1:0] MASKABLE_LANES = NSRC'(1) << SRC_INTR;

  // isolate lowest set bit: lowest index wins
  function automatic logic [NSRC-1:0] lowest_first(input logic [NSRC-1:0] v);
    return v & (~v + NSRC'(1));
  endfunction

  // lanes allowed to compete given the enable flag
  function automatic logic [NSRC-1:0] gate_mask(input logic [NSRC-1:0] pend,
                                                 input logic en);
    return en ? pend : (pend & ~MASKABLE_LANES);
  endfunction
endpackage

// File: rtl/irq_pending.sv
module irq_pending
  import irq_dispatch_pkg::*;
#(
  parameter int TYPE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          raise,
  input  logic [NSRC*TYPE_W-1:0]   raise_type,
  input  logic [NSRC-1:0]          clr,
  output logic [NSRC-1:0]          pend,
  output logic [NSRC*TYPE_W-1:0]   pend_type
);
  for (genvar i = 0; i < NSRC; i++) begin : g_lane
    logic              p_q;
    logic [TYPE_W-1:0] t_q;
    logic              take;

    assign take = raise[i] && (!p_q || clr[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        p_q <= 1'b0;
        t_q <= '0;
      end else if (take) begin
        p_q <= 1'b1;
        t_q <= raise_type[i*TYPE_W +: TYPE_W];
      end else if (clr[i]) begin
        p_q <= 1'b0;
      end
    end

    assign pend[i]                        = p_q;
    assign pend_type[i*TYPE_W +: TYPE_W]  = t_q;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_dispatch_pkg::*;
#(
  parameter int TYPE_W = 8
) (
  input  logic [NSRC-1:0]        pend,
  input  logic [NSRC*TYPE_W-1:0] pend_type,
  input  logic                   int_en,
  output logic [NSRC-1:0]        elig,
  output logic [NSRC-1:0]        grant,
  output logic [TYPE_W-1:0]      win_type,
  output logic                   any_elig
);
  assign elig     = gate_mask(pend, int_en);
  assign grant    = lowest_first(elig);
  assign any_elig = |elig;

  always_comb begin
    win_type = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) win_type = pend_type[i*TYPE_W +: TYPE_W];
    end
  end
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 8,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data
);
  logic [ADDR_W-1:0] mem [ENTRIES];

  // nonblocking update: a same-cycle read sees the previous contents
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int TYPE_W = 8,
  parameter int ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     int_en,
  input  logic [NSRC-1:0]          src_raise,
  input  logic [NSRC*TYPE_W-1:0]   src_type,
  input  logic                     tbl_wr_en,
  input  logic [TYPE_W-1:0]        tbl_wr_idx,
  input  logic [ADDR_W-1:0]        tbl_wr_data,
  input  logic                     disp_ack,
  output logic                     disp_valid,
  output logic [TYPE_W-1:0]        disp_type,
  output logic [ADDR_W-1:0]        disp_addr
);
  logic [NSRC-1:0]        pend;
  logic [NSRC*TYPE_W-1:0] pend_type;
  logic [NSRC-1:0]        elig;
  logic [NSRC-1:0]        grant;
  logic [TYPE_W-1:0]      win_type;
  logic                   any_elig;
  logic                   launch;
  logic                   ack_take;
  logic [NSRC-1:0]        clr;
  logic                   valid_q;
  logic [NSRC-1:0]        src_oh_q;
  logic [TYPE_W-1:0]      type_q;

  assign launch   = any_elig && !valid_q;
  assign ack_take = valid_q && disp_ack;
  assign clr      = {NSRC{ack_take}} & src_oh_q;

  irq_pending #(.TYPE_W(TYPE_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .raise(src_raise), .raise_type(src_type),
    .clr(clr), .pend(pend), .pend_type(pend_type)
  );

  irq_arbiter #(.TYPE_W(TYPE_W)) u_arb (
    .pend(pend), .pend_type(pend_type), .int_en(int_en),
    .elig(elig), .grant(grant), .win_type(win_type), .any_elig(any_elig)
  );

  irq_vec_table #(.ADDR_W(ADDR_W), .IDX_W(TYPE_W)) u_tbl (
    .clk(clk), .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_data(tbl_wr_data),
    .rd_en(launch), .rd_idx(win_type), .rd_data(disp_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      src_oh_q <= '0;
      type_q   <= '0;
    end else if (launch) begin
      valid_q  <= 1'b1;
      src_oh_q <= grant;
      type_q   <= win_type;
    end else if (ack_take) begin
      valid_q  <= 1'b0;
    end
  end

  assign disp_valid = valid_q;
  assign disp_type  = type_q;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
  import irq_dispatch_pkg::*;
#(
  parameter int TYPE_W = 8,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              int_en,
  input logic              disp_valid,
  input logic              disp_ack,
  input logic [TYPE_W-1:0] disp_type,
  input logic [ADDR_W-1:0] disp_addr,
  input logic [NSRC-1:0]   pend,
  input logic [NSRC-1:0]   elig,
  input logic [NSRC-1:0]   src_oh
);
  AST_PRIO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_valid) |-> ((($past(elig) & (src_oh - NSRC'(1))) == '0) &&
                           (($past(elig) & src_oh) != '0))); // R2

  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(disp_valid) && src_oh[SRC_INTR]) |-> $past(int_en)); // R3

  AST_NMI_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[SRC_NMI] && !disp_valid) |=> disp_valid); // R4

  AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((|elig) && !disp_valid) |=> disp_valid); // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ack) |=> (disp_valid && $stable(disp_type) &&
                                   $stable(disp_addr) && $stable(src_oh))); // R6

  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ack) |=> !disp_valid); // R7

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_valid && !(|elig)) |=> !disp_valid); // R10
endmodule

bind irq_dispatch irq_dispatch_chk #(.TYPE_W(TYPE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_en(int_en), .disp_valid(disp_valid),
  .disp_ack(disp_ack), .disp_type(disp_type), .disp_addr(disp_addr),
  .pend(pend), .elig(elig), .src_oh(src_oh_q)
);

// File: tb/tb_irq_dispatch.sv
module tb_irq_dispatch;
  localparam int NS = 6;
  localparam int TW = 8;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          int_en = 1'b0;
  logic [NS-1:0] src_raise = '0;
  logic [NS*TW-1:0] src_type = '0;
  logic          tbl_wr_en = 1'b0;
  logic [TW-1:0] tbl_wr_idx = '0;
  logic [AW-1:0] tbl_wr_data = '0;
  logic          disp_ack = 1'b0;
  logic          disp_valid;
  logic [TW-1:0] disp_type;
  logic [AW-1:0] disp_addr;

  irq_dispatch #(.TYPE_W(TW), .ADDR_W(AW)) dut (.*);

  always #10 clk = ~clk;

  typedef struct { logic [TW-1:0] typ; logic [AW-1:0] addr; } exp_t;
  exp_t exp_q[$];
  logic [AW-1:0] model [256];
  int checks = 0;
  int fails  = 0;

  function automatic logic [AW-1:0] vec_fn(input int i);
    return 32'h4000_0000 + 32'(i) * 32'h0001_0010 + 32'h7;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: raise a set of lanes for one cycle, queue expected dispatches
  task automatic raise(input logic [NS-1:0] lanes, input logic [NS*TW-1:0] types);
    src_raise = lanes;
    src_type  = types;
    @(negedge clk);
    src_raise = '0;
  endtask

  task automatic expect_disp(input logic [TW-1:0] t);
    exp_t e;
    e.typ  = t;
    e.addr = model[t];
    exp_q.push_back(e);
  endtask

  function automatic logic [NS*TW-1:0] slot(input int lane, input logic [TW-1:0] t);
    return (NS*TW)'(t) << (lane*TW);
  endfunction

  // monitor: wait for a dispatch, compare against the queue, acknowledge
  task automatic service_one(input string req);
    exp_t e;
    int waited = 0;
    while (!disp_valid && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    if (!disp_valid) begin
      check(1'b0, req, 0, 1);
      return;
    end
    if (exp_q.size() == 0) begin
      check(1'b0, req, 64'(disp_type), 0);
      return;
    end
    e = exp_q.pop_front();
    check(disp_type == e.typ, req, 64'(disp_type), 64'(e.typ));
    check(disp_addr == e.addr, req, 64'(disp_addr), 64'(e.addr));
    disp_ack = 1'b1;
    @(negedge clk);
    disp_ack = 1'b0;
    check(disp_valid == 1'b0, "R7 strobe drops after ack", 64'(disp_valid), 0);
  endtask

  task automatic idle_for(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(disp_valid == 1'b0, req, 64'(disp_valid), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(disp_valid == 1'b0, "R1 reset idle", 64'(disp_valid), 0);
    idle_for(2, "R1 nothing pending after reset");

    // load table
    for (int i = 0; i < 256; i++) begin
      model[i]    = vec_fn(i);
      tbl_wr_en   = 1'b1;
      tbl_wr_idx  = TW'(i);
      tbl_wr_data = vec_fn(i);
      @(negedge clk);
    end
    tbl_wr_en = 1'b0;
    int_en    = 1'b1;

    // R5 timing and R6 hold
    expect_disp(8'h30);
    raise(6'b001000, slot(3, 8'h30));
    check(disp_valid == 1'b0, "R5 not yet valid one cycle after raise", 64'(disp_valid), 0);
    @(negedge clk);
    check(disp_valid == 1'b1, "R5 valid two cycles after raise", 64'(disp_valid), 1);
    check(disp_type == 8'h30, "R5 type", 64'(disp_type), 64'h30);
    check(disp_addr == model[8'h30], "R5 addr", 64'(disp_addr), 64'(model[8'h30]));
    repeat (3) @(negedge clk);
    check(disp_valid == 1'b1 && disp_type == 8'h30 && disp_addr == model[8'h30],
          "R6 outputs held", 64'(disp_addr), 64'(model[8'h30]));
    service_one("R5 fetch fault");

    // R2 all lanes at once, types at both range ends
    for (int l = 0; l < NS; l++) expect_disp(l == 0 ? 8'hFF : (l == 5 ? 8'h00 : TW'(8'h10 + l)));
    raise(6'b111111, slot(0, 8'hFF) | slot(1, 8'h11) | slot(2, 8'h12) |
                     slot(3, 8'h13) | slot(4, 8'h14) | slot(5, 8'h00));
    for (int l = 0; l < NS; l++) service_one("R2 priority order");
    idle_for(3, "R7 all lanes serviced");

    // R3 masking
    int_en = 1'b0;
    expect_disp(8'h13);
    raise(6'b100100, slot(2, 8'h21) | slot(5, 8'h13));
    service_one("R3 masked lane skipped");
    idle_for(4, "R3 masked lane held back");
    int_en = 1'b1;
    expect_disp(8'h21);
    service_one("R3 masked lane after enable");

    // R4 non-maskable with enable low
    int_en = 1'b0;
    expect_disp(8'h02);
    raise(6'b000110, slot(1, 8'h02) | slot(2, 8'h22));
    service_one("R4 non-maskable dispatched");
    idle_for(3, "R3 maskable still held");
    int_en = 1'b1;
    expect_disp(8'h22);
    service_one("R7 remaining lane kept pending");

    // R8 write collision
    raise(6'b010000, slot(4, 8'h77));
    expect_disp(8'h77);
    tbl_wr_en   = 1'b1;
    tbl_wr_idx  = 8'h77;
    tbl_wr_data = 32'hDEAD_BEE0;
    @(negedge clk);
    tbl_wr_en = 1'b0;
    model[8'h77] = 32'hDEAD_BEE0;
    service_one("R8 old value on collision");
    expect_disp(8'h77);
    raise(6'b010000, slot(4, 8'h77));
    service_one("R8 new value afterwards");

    // R9 second raise on pending lane
    expect_disp(8'h11);
    raise(6'b000001, slot(0, 8'h11));
    raise(6'b000001, slot(0, 8'h12));
    service_one("R9 first type kept");
    idle_for(4, "R9 no second dispatch");

    // R10 ack while idle
    expect_disp(8'h33);
    raise(6'b001000, slot(3, 8'h33));
    disp_ack = 1'b1;
    @(negedge clk);
    disp_ack = 1'b0;
    check(disp_valid == 1'b1, "R10 early ack ignored", 64'(disp_valid), 1);
    @(negedge clk);
    check(disp_valid == 1'b1, "R10 dispatch still held", 64'(disp_valid), 1);
    service_one("R10 dispatch after stray ack");
    check(exp_q.size() == 0, "R7 scoreboard drained", 64'(exp_q.size()), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule